// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Bus Engine

This block carries out one serial bus transaction over a single shared data wire and a clock that it generates itself. A host loads a write word, a write bit count, a read bit count and the engine clock frequency in kHz, then pulses `start`. The engine sends the leading write bits onto the data wire. It then releases the wire and clocks in the response bits. Finally it waits for the peripheral to pull the shared wire high as an event, and signals the host with a one-cycle interrupt.

The engine moves forward only on cycles where the `tick` enable from an external clock divider is high, so one engine step lasts one tick period. The frequency value picks one of three turnaround profiles when the transaction starts. A slow engine turns the wire around in one step. A fast engine adds a clock-high step. An engine running beyond the nominal limit adds both a clock-high step and a clock-low step, which gives the peripheral more time to stop driving the wire.

Top module: `spi3w_engine`

## Requirements
- R1: While idle, a cycle with `start` high latches all inputs and raises `busy` from the next cycle. Write counts run from 1 to 32. The engine sends `wr_bits` bits most significant first, starting with `wr_data[31]`, and each bit is captured on a rising `sclk`.
- R2: Each write bit takes two engine steps: one with `sclk` low and `sdio_out` driven, then one with `sclk` high. `sdio_out` does not change while `sclk` is high and `sdio_oe` is 1.
- R3: After the last write bit, `sdio_oe` falls while `sclk` is low, and the engine stays in that state for one step.
- R4: The turnaround profile follows `eng_khz`. Above 100000 it is overclock. From 75000 up to and including 100000 it is high speed. Below 75000 it is low speed. From the fall of `sdio_oe`, the first read rising edge of `sclk` comes after 2, 3 or 4 steps (low, high, overclock). High and overclock each add exactly one extra `sclk` rise.
- R5: The engine reads `rd_bits` bits, sampling `sdio_in` during the clock-low step. The first bit received lands in `rd_data[rd_bits-1]` and the last in `rd_data[0]`. Bits above these read as zero.
- R6: When `rd_bits` is 0, no turnaround or read steps take place and `sclk` does not rise after `sdio_oe` falls.
- R7: After the read phase, `sclk` stays low and `irq` does not assert until `sdio_in` is 1 on a tick.
- R8: `irq` is high for exactly one cycle, and `busy` is already low in that cycle.
- R9: A `start` pulse while `busy` is high has no effect on the running transaction and starts no new one.
- R10: Engine state changes only on cycles where `tick` is high. With a tick every N cycles, every step lasts N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Step enable from the clock divider |
| start | input | 1 | Begin a transaction when idle |
| eng_khz | input | 20 | Effective engine clock in kHz, selects turnaround profile |
| wr_bits | input | 6 | Number of bits to write (1..32) |
| rd_bits | input | 6 | Number of bits to read (0..32) |
| wr_data | input | 32 | Write word, sent from bit 31 downward |
| sdio_in | input | 1 | Shared data wire, input side |
| sclk | output | 1 | Serial clock |
| sdio_out | output | 1 | Shared data wire, output value |
| sdio_oe | output | 1 | Output enable of the shared data wire |
| busy | output | 1 | Transaction in progress |
| irq | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Received bits, right-aligned |

## Verification
The assertions assume that `wr_bits` is never zero and that the shared wire is high on the completing tick. They also assume that `tick` is the only thing that moves a busy engine. The stimulus always uses write counts from 1 to 32. It holds `sdio_in` low for several cycles after the last read rise and only then raises it, so an early completion can be seen. Ticks come from a periodic counter in the bench with periods of 1 to 3 cycles. The bench changes that period only while the engine is idle.

// File: rtl/spi3w_engine.sv
module spi3w_engine #(
  parameter int DW     = 32,
  parameter int FW     = 20,
  parameter int HI_KHZ = 75000,
  parameter int OC_KHZ = 100000,
  localparam int CW    = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [FW-1:0] eng_khz,
  input  logic [CW-1:0] wr_bits,
  input  logic [CW-1:0] rd_bits,
  input  logic [DW-1:0] wr_data,
  input  logic          sdio_in,
  output logic          sclk,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          busy,
  output logic          irq,
  output logic [DW-1:0] rd_data
);
  typedef enum logic [3:0] {
    S_IDLE, S_WLO, S_WHI, S_TURN, S_X1, S_X2, S_RLO, S_RHI, S_EVT
  } st_t;

  localparam logic [FW-1:0] HI_L = FW'(HI_KHZ);
  localparam logic [FW-1:0] OC_L = FW'(OC_KHZ);

  st_t           state;
  logic [DW-1:0] shreg, rsh;
  logic [CW-1:0] wcnt, rcnt;
  logic [1:0]    mode_q, mode_sel;
  logic          rzero;

  assign mode_sel = (eng_khz > OC_L) ? 2'd2 : (eng_khz >= HI_L) ? 2'd1 : 2'd0;
  assign busy     = (state != S_IDLE);
  assign sdio_oe  = (state == S_WLO) || (state == S_WHI);
  assign sdio_out = sdio_oe & shreg[DW-1];
  assign sclk     = (state == S_WHI) || (state == S_X1) || (state == S_RHI);
  assign rd_data  = rsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      shreg  <= '0;
      rsh    <= '0;
      wcnt   <= '0;
      rcnt   <= '0;
      mode_q <= 2'd0;
      rzero  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          shreg  <= wr_data;
          rsh    <= '0;
          wcnt   <= wr_bits - CW'(1);
          rcnt   <= rd_bits - CW'(1);
          rzero  <= (rd_bits == '0);
          mode_q <= mode_sel;
          state  <= S_WLO;
        end
      end else if (tick) begin
        case (state)
          S_WLO: state <= S_WHI;
          S_WHI: begin
            shreg <= shreg << 1;
            if (wcnt == '0) state <= S_TURN;
            else begin
              wcnt  <= wcnt - CW'(1);
              state <= S_WLO;
            end
          end
          S_TURN: state <= rzero ? S_EVT : (mode_q == 2'd0) ? S_RLO : S_X1;
          S_X1:   state <= (mode_q == 2'd2) ? S_X2 : S_RLO;
          S_X2:   state <= S_RLO;
          S_RLO: begin
            rsh   <= {rsh[DW-2:0], sdio_in};
            state <= S_RHI;
          end
          S_RHI: begin
            if (rcnt == '0) state <= S_EVT;
            else begin
              rcnt  <= rcnt - CW'(1);
              state <= S_RLO;
            end
          end
          S_EVT: begin
            if (sdio_in) begin
              irq   <= 1'b1;
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && sclk) |-> $stable(sdio_out)); // R2
  AST_TURN_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> !sclk); // R3
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(sdio_in) && $past(tick))); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !tick) |=> (busy && $stable(mode_q))); // R9
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(state)); // R10
endmodule

// File: tb/spi3w_engine_tb_top.sv
module spi3w_engine_tb_top;
  logic        clk = 0, rst_n = 0, tick = 0, start = 0, sdio_in = 0;
  logic [19:0] eng_khz = '0;
  logic [5:0]  wr_bits = 6'd1, rd_bits = '0;
  logic [31:0] wr_data = '0;
  logic        sclk, sdio_out, sdio_oe, busy, irq;
  logic [31:0] rd_data;

  spi3w_engine dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .eng_khz(eng_khz),
    .wr_bits(wr_bits), .rd_bits(rd_bits), .wr_data(wr_data), .sdio_in(sdio_in), .sclk(sclk),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .busy(busy), .irq(irq), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] wd; int wn; logic [31:0] rw; int rn; int khz; int div; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, pushed = 0, done_cnt = 0, div = 1, tcnt = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: got %h expected %h", req, act, exp); end
  endtask

  function automatic int mode_of(int khz);
    return (khz > 100000) ? 2 : (khz >= 75000) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= div) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  // monitor / scoreboard
  item_t cur;
  bit active = 0, fallen = 0, r2ok = 1, irq_low_chk = 0;
  logic ps = 0, pout = 0, poe = 0, pb = 0;
  logic [31:0] wcap;
  int wcap_n, rises, reads, hold, t_fall, t_first, cyc = 0, extra;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (irq_low_chk) begin chk(!irq, "R8 irq one cycle", {31'd0, irq}, 0); irq_low_chk = 0; end
      if (!pb && busy) begin
        cur = q.pop_front();
        active = 1; fallen = 0; r2ok = 1; wcap = '0; wcap_n = 0; rises = 0; reads = 0;
        hold = 0; t_first = -1; extra = (mode_of(cur.khz) == 0) ? 0 : 1;
      end
      if (active) begin
        if (sdio_oe && sclk && !ps) begin wcap = {wcap[30:0], sdio_out}; wcap_n++; end
        if (sdio_oe && sclk && sdio_out != pout) r2ok = 0;
        if (poe && !sdio_oe && busy) begin
          fallen = 1; t_fall = cyc;
          chk(!sclk, "R3 oe falls with sclk low", {31'd0, sclk}, 0);
        end
        if (fallen && sclk && !ps) begin
          rises++;
          if (rises == extra + 1) t_first = cyc;
          if (rises > extra) reads++;
        end
        if (fallen && reads >= cur.rn) begin
          if (hold < 8) begin sdio_in = 0; hold++; end else sdio_in = 1;
        end else if (reads < cur.rn) sdio_in = cur.rw[cur.rn - 1 - reads];
        if (irq) begin
          done_cnt++;
          chk(wcap_n == cur.wn, "R1 write bit count", wcap_n, cur.wn);
          chk(wcap == (cur.wd >> (32 - cur.wn)), "R1 write bits msb first", wcap, cur.wd >> (32 - cur.wn));
          chk(r2ok, "R2 data stable while sclk high", {31'd0, r2ok}, 1);
          if (cur.rn > 0) begin
            int f;
            f = (mode_of(cur.khz) == 0) ? 2 : (mode_of(cur.khz) == 1) ? 3 : 4;
            chk(t_first - t_fall == f * cur.div, "R4/R10 turnaround cycles", t_first - t_fall, f * cur.div);
            chk(rises == cur.rn + extra, "R4 read-side sclk rises", rises, cur.rn + extra);
          end else
            chk(rises == 0, "R6 no read clocks when rd_bits=0", rises, 0);
          chk(rd_data == ((cur.rn == 32) ? cur.rw : (cur.rw & ((32'd1 << cur.rn) - 1))),
              "R5 read data", rd_data, (cur.rn == 32) ? cur.rw : (cur.rw & ((32'd1 << cur.rn) - 1)));
          chk(hold >= 8, "R7 irq only after event", hold, 8);
          chk(!busy, "R8 busy low with irq", {31'd0, busy}, 0);
          active = 0; irq_low_chk = 1; sdio_in = 0;
        end
      end
    end
    ps = sclk; pout = sdio_out; poe = sdio_oe; pb = busy;
  end

  task automatic run(logic [31:0] wd, int wn, logic [31:0] rw, int rn, int khz, int d, bit dup);
    item_t it;
    it.wd = wd; it.wn = wn; it.rw = rw; it.rn = rn; it.khz = khz; it.div = d;
    div = d; q.push_back(it); pushed++;
    @(negedge clk);
    eng_khz = 20'(khz); wr_bits = 6'(wn); rd_bits = 6'(rn); wr_data = wd; start = 1;
    @(negedge clk); start = 0;
    if (dup) begin
      repeat (6) @(negedge clk);
      wr_data = ~wd; eng_khz = 20'd1000; rd_bits = 6'd0; start = 1;   // R9 start while busy
      @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(!busy, "R9 no stray transaction", {31'd0, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({sclk, sdio_oe, busy, irq} == 4'b0, "R1 reset state", {28'd0, sclk, sdio_oe, busy, irq}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({sclk, sdio_oe, busy, irq} == 4'b0, "R1 idle after reset", {28'd0, sclk, sdio_oe, busy, irq}, 0);
    run(32'hA5C3_0000, 8,  32'h0000_005A, 8,  50000,  1, 0);
    run(32'h1234_5678, 16, 32'hDEAD_BEEF, 32, 75000,  1, 0);
    run(32'hF0F0_0000, 12, 32'h0000_0B3C, 12, 100000, 2, 0);
    run(32'h8001_7FFE, 32, 32'h0000_0015, 5,  100001, 1, 0);
    run(32'h8000_0000, 1,  32'h0000_0001, 1,  74999,  1, 0);
    run(32'h6C00_0000, 6,  32'h0000_0000, 0,  133000, 1, 0);
    run(32'h3C5A_0000, 16, 32'h0000_9A6B, 16, 133000, 3, 1);
    run(32'hFFFF_FFFF, 24, 32'h0000_0001, 3,  90000,  2, 1);
    chk(done_cnt == pushed && q.size() == 0, "R9 one completion per accepted start", done_cnt, pushed);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule